// File: doc/BRIEF.md
# Banked Exception Acknowledge and Completion Tracker

This block keeps the pending, enabled and active state for a small set of numbered exceptions. Some exception numbers are banked: they carry two independent copies of their state, one for the secure world and one for the non-secure world. The other numbers have a single shared copy plus a routing bit that says which security state takes them. Arbitration happens elsewhere. The block is given the winning pending exception, its priority and the current execution priority, and it only carries out the state change.

An acknowledge pulse takes the offered pending exception into the active state. It records that number as the exception now being handled, and reports whether the handler runs in the secure state. A complete pulse names an exception number and a security flag, and clears the matching active bit. It returns a two-bit code that says one of three things: the exit was illegal, other exceptions are still active, or the core has returned to base level. Both results are registered and show up one cycle after their request, together with a done strobe. Configuration ports set the enable and routing bits and mark entries pending.

Top module: `exc_bank_ctrl`

## Requirements
- R1: After reset every pending, active and enable bit in both banks is clear, cur_exc is 0 and all result outputs are 0.
- R2: An acknowledge whose vec_pend_sec is 1 uses the secure-bank entry and, when it succeeds, reports ack_secure = 1.
- R3: An acknowledge whose vec_pend_sec is 0 uses the non-secure/shared entry and reports ack_secure = 1 only if the number is not banked and its routing bit is 1.
- R4: A successful acknowledge sets the entry's active bit, clears its pending bit and loads cur_exc with the number. ack_done is high for exactly the cycle after each ack_req, and cur_exc changes only on a successful acknowledge.
- R5: An acknowledge whose entry is not enabled, or not pending, or whose vec_pend_prio is not strictly lower than exec_prio, gives ack_err = 1 and ack_secure = 0, and changes no state.
- R6: A complete uses the secure-bank entry only when cmp_sec is 1 and the number is banked. Otherwise it uses the non-secure/shared entry.
- R7: A complete of an entry that is not active returns cmp_status = 2'b10 and changes no state.
- R8: A valid complete clears the active bit and returns 2'b01 if no entry in either bank is still active, or 2'b00 otherwise. cmp_done is high in the cycle after cmp_req.
- R9: Numbers at or below RESET_NUM (default 1) or at or above NUM_EXC (default 12) are illegal. An acknowledge of such a number gives ack_err, and a complete of one returns 2'b10.
- R10: When ack_req and cmp_req arrive in the same cycle, the complete is evaluated first, on the state before the acknowledge, and then the acknowledge is applied.
- R11: cfg_we writes the enable bit, and pend_set sets the pending bit, of the secure bank only when the security flag is 1 and the number is banked (default banked numbers 2 to 5, mask 12'h03C). Otherwise they write the non-secure/shared entry. cfg_route is kept only for legal non-banked numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write enable and routing bit for cfg_num |
| cfg_num | input | EXC_W | Exception number to configure |
| cfg_sec | input | 1 | Selects the secure bank for banked numbers |
| cfg_en | input | 1 | Enable value to write |
| cfg_route | input | 1 | Routing value (1 = secure) for non-banked numbers |
| pend_set | input | 1 | Mark pend_num pending |
| pend_num | input | EXC_W | Exception number to mark pending |
| pend_sec | input | 1 | Selects the secure bank for banked numbers |
| vec_pend_num | input | EXC_W | Arbitrated pending exception number |
| vec_pend_sec | input | 1 | Arbitrated entry lies in the secure bank |
| vec_pend_prio | input | PRIO_W | Priority of the arbitrated entry |
| exec_prio | input | PRIO_W | Current execution priority |
| ack_req | input | 1 | Acknowledge pulse |
| ack_done | output | 1 | Acknowledge result valid |
| ack_err | output | 1 | Acknowledge refused |
| ack_secure | output | 1 | Handler runs in the secure state |
| cur_exc | output | EXC_W | Exception number being handled |
| cmp_req | input | 1 | Complete pulse |
| cmp_num | input | EXC_W | Exception number to complete |
| cmp_sec | input | 1 | Completing exception was secure |
| cmp_done | output | 1 | Complete result valid |
| cmp_status | output | 2 | 00 still active, 01 back to base, 10 not active or illegal |

## Verification
Every cycle, the bound checker checks that each request gets exactly one done strobe, that a refusal never claims the secure state, and that secure-bank acknowledges report secure. It also checks that priority and range violations are refused and that cur_exc moves only on a successful acknowledge. The bank that a request actually touches, the back-to-base code, and the separation of the two copies of a banked entry can only be seen across sequences of requests. The bench sweeps every number, bank and routing setting, and adds nested, dual-bank and same-cycle scenarios to cover them.

// File: rtl/exc_bank_pkg.sv
package exc_bank_pkg;
   typedef enum logic [1:0] {
      CMP_NESTED = 2'b00,
      CMP_BASE   = 2'b01,
      CMP_BADRET = 2'b10
   } cmp_stat_e;

   localparam int unsigned MAX_EXC = 64;

   function automatic logic pick_bit(input logic [MAX_EXC-1:0] vec, input int unsigned idx);
      logic r;
      r = 1'b0;
      for (int unsigned i = 0; i < MAX_EXC; i++) begin
         if (i == idx) r = vec[i];
      end
      return r;
   endfunction
endpackage

// File: rtl/exc_bank_store.sv
module exc_bank_store #(
   parameter int unsigned          NUM_EXC = 12,
   parameter int unsigned          EXC_W   = 4,
   parameter logic [NUM_EXC-1:0]   PRESENT = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_we,
   input  logic [EXC_W-1:0]   en_num,
   input  logic               en_val,
   input  logic               pend_we,
   input  logic [EXC_W-1:0]   pend_num,
   input  logic               ack_hit,
   input  logic [EXC_W-1:0]   ack_num,
   input  logic               clr_hit,
   input  logic [EXC_W-1:0]   clr_num,
   output logic [NUM_EXC-1:0] en_vec,
   output logic [NUM_EXC-1:0] pend_vec,
   output logic [NUM_EXC-1:0] act_vec
);
   for (genvar i = 0; i < NUM_EXC; i++) begin : g_ent
      if (PRESENT[i]) begin : g_live
         logic sel_en, sel_pend, sel_ack, sel_clr;
         assign sel_en   = en_we   && (en_num   == EXC_W'(i));
         assign sel_pend = pend_we && (pend_num == EXC_W'(i));
         assign sel_ack  = ack_hit && (ack_num  == EXC_W'(i));
         assign sel_clr  = clr_hit && (clr_num  == EXC_W'(i));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               en_vec[i]   <= 1'b0;
               pend_vec[i] <= 1'b0;
               act_vec[i]  <= 1'b0;
            end else begin
               if (sel_en) en_vec[i] <= en_val;
               pend_vec[i] <= (pend_vec[i] & ~sel_ack) | sel_pend;
               act_vec[i]  <= (act_vec[i] & ~sel_clr) | sel_ack;
            end
         end
      end else begin : g_none
         assign en_vec[i]   = 1'b0;
         assign pend_vec[i] = 1'b0;
         assign act_vec[i]  = 1'b0;
      end
   end
endmodule

// File: rtl/exc_ack_eval.sv
module exc_ack_eval
   import exc_bank_pkg::*;
#(
   parameter int unsigned        NUM_EXC   = 12,
   parameter int unsigned        EXC_W     = 4,
   parameter int unsigned        PRIO_W    = 4,
   parameter int unsigned        RESET_NUM = 1,
   parameter logic [NUM_EXC-1:0] BANKED    = '0
) (
   input  logic [EXC_W-1:0]   num,
   input  logic               sec,
   input  logic [PRIO_W-1:0]  prio,
   input  logic [PRIO_W-1:0]  exec_prio,
   input  logic [NUM_EXC-1:0] en_ns,
   input  logic [NUM_EXC-1:0] pend_ns,
   input  logic [NUM_EXC-1:0] en_s,
   input  logic [NUM_EXC-1:0] pend_s,
   input  logic [NUM_EXC-1:0] route,
   output logic               ok,
   output logic               tgt_sec
);
   logic legal, banked, en_b, pend_b;
   int unsigned idx;

   always_comb begin
      idx     = int'(num);
      legal   = (idx > RESET_NUM) && (idx < NUM_EXC);
      banked  = pick_bit(MAX_EXC'(BANKED), idx);
      en_b    = sec ? pick_bit(MAX_EXC'(en_s), idx)   : pick_bit(MAX_EXC'(en_ns), idx);
      pend_b  = sec ? pick_bit(MAX_EXC'(pend_s), idx) : pick_bit(MAX_EXC'(pend_ns), idx);
      ok      = legal && en_b && pend_b && (prio < exec_prio);
      tgt_sec = ok && (sec || (!banked && pick_bit(MAX_EXC'(route), idx)));
   end
endmodule

// File: rtl/exc_cmp_eval.sv
module exc_cmp_eval
   import exc_bank_pkg::*;
#(
   parameter int unsigned        NUM_EXC   = 12,
   parameter int unsigned        EXC_W     = 4,
   parameter int unsigned        RESET_NUM = 1,
   parameter logic [NUM_EXC-1:0] BANKED    = '0
) (
   input  logic [EXC_W-1:0]   num,
   input  logic               sec,
   input  logic [NUM_EXC-1:0] act_ns,
   input  logic [NUM_EXC-1:0] act_s,
   output logic               hit,
   output logic               sel_sec,
   output cmp_stat_e          status
);
   logic legal, was_act, remain;
   logic [NUM_EXC-1:0] mask;
   int unsigned idx;

   always_comb begin
      idx     = int'(num);
      legal   = (idx > RESET_NUM) && (idx < NUM_EXC);
      sel_sec = sec && pick_bit(MAX_EXC'(BANKED), idx);
      was_act = legal && (sel_sec ? pick_bit(MAX_EXC'(act_s), idx)
                                  : pick_bit(MAX_EXC'(act_ns), idx));
      mask    = '0;
      for (int unsigned i = 0; i < NUM_EXC; i++) begin
         if (i == idx) mask[i] = was_act;
      end
      remain  = |(act_ns & ~(sel_sec ? '0 : mask)) | |(act_s & ~(sel_sec ? mask : '0));
      hit     = was_act;
      if (!was_act)    status = CMP_BADRET;
      else if (remain) status = CMP_NESTED;
      else             status = CMP_BASE;
   end
endmodule

// File: rtl/exc_bank_ctrl.sv
module exc_bank_ctrl
   import exc_bank_pkg::*;
#(
   parameter int unsigned        NUM_EXC     = 12,
   parameter int unsigned        PRIO_W      = 4,
   parameter int unsigned        RESET_NUM   = 1,
   parameter logic [NUM_EXC-1:0] BANKED_MASK = 12'h03C,
   parameter int unsigned        EXC_W       = $clog2(NUM_EXC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [EXC_W-1:0]  cfg_num,
   input  logic              cfg_sec,
   input  logic              cfg_en,
   input  logic              cfg_route,
   input  logic              pend_set,
   input  logic [EXC_W-1:0]  pend_num,
   input  logic              pend_sec,
   input  logic [EXC_W-1:0]  vec_pend_num,
   input  logic              vec_pend_sec,
   input  logic [PRIO_W-1:0] vec_pend_prio,
   input  logic [PRIO_W-1:0] exec_prio,
   input  logic              ack_req,
   output logic              ack_done,
   output logic              ack_err,
   output logic              ack_secure,
   output logic [EXC_W-1:0]  cur_exc,
   input  logic              cmp_req,
   input  logic [EXC_W-1:0]  cmp_num,
   input  logic              cmp_sec,
   output logic              cmp_done,
   output logic [1:0]        cmp_status
);
   function automatic logic [NUM_EXC-1:0] legal_fn();
      logic [NUM_EXC-1:0] m;
      for (int unsigned i = 0; i < NUM_EXC; i++) m[i] = (i > RESET_NUM);
      return m;
   endfunction

   localparam logic [NUM_EXC-1:0] LEGAL_MASK  = legal_fn();
   localparam logic [NUM_EXC-1:0] SEC_PRESENT = LEGAL_MASK & BANKED_MASK;
   localparam logic [NUM_EXC-1:0] RTE_PRESENT = LEGAL_MASK & ~BANKED_MASK;

   if (NUM_EXC > MAX_EXC) begin : g_bad_num
      $error("NUM_EXC exceeds the supported maximum");
   end
   if (NUM_EXC < RESET_NUM + 2) begin : g_bad_rst
      $error("NUM_EXC leaves no legal exception number");
   end
   if ((2 ** EXC_W) < NUM_EXC) begin : g_bad_w
      $error("EXC_W too narrow for NUM_EXC");
   end
   if (PRIO_W < 1) begin : g_bad_p
      $error("PRIO_W must be at least 1");
   end

   logic [NUM_EXC-1:0] en_ns, pend_ns, act_ns;
   logic [NUM_EXC-1:0] en_s, pend_s, act_s;
   logic [NUM_EXC-1:0] route_q;
   logic cfg_to_s, pend_to_s;
   logic ack_ok, ack_tgt, ack_fire;
   logic cmp_hit, cmp_to_s, cmp_fire;
   cmp_stat_e cmp_code;

   assign cfg_to_s  = cfg_sec  && pick_bit(MAX_EXC'(BANKED_MASK), int'(cfg_num));
   assign pend_to_s = pend_sec && pick_bit(MAX_EXC'(BANKED_MASK), int'(pend_num));

   for (genvar i = 0; i < NUM_EXC; i++) begin : g_rte
      if (RTE_PRESENT[i]) begin : g_keep
         always_ff @(posedge clk) begin
            if (!rst_n) route_q[i] <= 1'b0;
            else if (cfg_we && cfg_num == EXC_W'(i)) route_q[i] <= cfg_route;
         end
      end else begin : g_tie
         assign route_q[i] = 1'b0;
      end
   end

   exc_ack_eval #(
      .NUM_EXC(NUM_EXC), .EXC_W(EXC_W), .PRIO_W(PRIO_W),
      .RESET_NUM(RESET_NUM), .BANKED(BANKED_MASK)
   ) u_ack (
      .num(vec_pend_num), .sec(vec_pend_sec), .prio(vec_pend_prio),
      .exec_prio(exec_prio), .en_ns(en_ns), .pend_ns(pend_ns),
      .en_s(en_s), .pend_s(pend_s), .route(route_q),
      .ok(ack_ok), .tgt_sec(ack_tgt)
   );

   exc_cmp_eval #(
      .NUM_EXC(NUM_EXC), .EXC_W(EXC_W),
      .RESET_NUM(RESET_NUM), .BANKED(BANKED_MASK)
   ) u_cmp (
      .num(cmp_num), .sec(cmp_sec), .act_ns(act_ns), .act_s(act_s),
      .hit(cmp_hit), .sel_sec(cmp_to_s), .status(cmp_code)
   );

   assign ack_fire = ack_req && ack_ok;
   assign cmp_fire = cmp_req && cmp_hit;

   exc_bank_store #(.NUM_EXC(NUM_EXC), .EXC_W(EXC_W), .PRESENT(LEGAL_MASK)) u_ns (
      .clk(clk), .rst_n(rst_n),
      .en_we(cfg_we && !cfg_to_s), .en_num(cfg_num), .en_val(cfg_en),
      .pend_we(pend_set && !pend_to_s), .pend_num(pend_num),
      .ack_hit(ack_fire && !vec_pend_sec), .ack_num(vec_pend_num),
      .clr_hit(cmp_fire && !cmp_to_s), .clr_num(cmp_num),
      .en_vec(en_ns), .pend_vec(pend_ns), .act_vec(act_ns)
   );

   exc_bank_store #(.NUM_EXC(NUM_EXC), .EXC_W(EXC_W), .PRESENT(SEC_PRESENT)) u_s (
      .clk(clk), .rst_n(rst_n),
      .en_we(cfg_we && cfg_to_s), .en_num(cfg_num), .en_val(cfg_en),
      .pend_we(pend_set && pend_to_s), .pend_num(pend_num),
      .ack_hit(ack_fire && vec_pend_sec), .ack_num(vec_pend_num),
      .clr_hit(cmp_fire && cmp_to_s), .clr_num(cmp_num),
      .en_vec(en_s), .pend_vec(pend_s), .act_vec(act_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_done   <= 1'b0;
         ack_err    <= 1'b0;
         ack_secure <= 1'b0;
         cur_exc    <= '0;
         cmp_done   <= 1'b0;
         cmp_status <= 2'b00;
      end else begin
         ack_done   <= ack_req;
         ack_err    <= ack_req && !ack_ok;
         ack_secure <= ack_fire && ack_tgt;
         if (ack_fire) cur_exc <= vec_pend_num;
         cmp_done   <= cmp_req;
         cmp_status <= cmp_req ? 2'(cmp_code) : 2'b00;
      end
   end
endmodule

// File: rtl/exc_bank_chk.sv
module exc_bank_chk #(
   parameter int unsigned NUM_EXC   = 12,
   parameter int unsigned EXC_W     = 4,
   parameter int unsigned PRIO_W    = 4,
   parameter int unsigned RESET_NUM = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack_req,
   input logic              cmp_req,
   input logic [EXC_W-1:0]  vec_pend_num,
   input logic              vec_pend_sec,
   input logic [PRIO_W-1:0] vec_pend_prio,
   input logic [PRIO_W-1:0] exec_prio,
   input logic              ack_done,
   input logic              ack_err,
   input logic              ack_secure,
   input logic [EXC_W-1:0]  cur_exc,
   input logic              cmp_done,
   input logic [1:0]        cmp_status
);
   AST_ACK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req |=> ack_done); // R4
   AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_req |=> !ack_done && !ack_err && !ack_secure); // R4
   AST_PRIO_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req && (vec_pend_prio >= exec_prio) |=> ack_err); // R5
   AST_ERR_NOT_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_err |-> !ack_secure); // R5
   AST_SEC_BANK_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req && vec_pend_sec |=> ack_err || ack_secure); // R2
   AST_CUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_req |=> $stable(cur_exc)); // R4
   AST_CUR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req |=> ack_err || (cur_exc == $past(vec_pend_num))); // R4
   AST_CMP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_req |=> cmp_done && (cmp_status != 2'b11)); // R8
   AST_CMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_req |=> !cmp_done && (cmp_status == 2'b00)); // R8
   AST_ILLEGAL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req && ((int'(vec_pend_num) <= RESET_NUM) || (int'(vec_pend_num) >= NUM_EXC))
      |=> ack_err); // R9
endmodule

bind exc_bank_ctrl exc_bank_chk #(
   .NUM_EXC(NUM_EXC), .EXC_W(EXC_W), .PRIO_W(PRIO_W), .RESET_NUM(RESET_NUM)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .cmp_req(cmp_req),
   .vec_pend_num(vec_pend_num), .vec_pend_sec(vec_pend_sec),
   .vec_pend_prio(vec_pend_prio), .exec_prio(exec_prio),
   .ack_done(ack_done), .ack_err(ack_err), .ack_secure(ack_secure),
   .cur_exc(cur_exc), .cmp_done(cmp_done), .cmp_status(cmp_status)
);

// File: tb/exc_bank_ctrl_test.sv
module exc_bank_ctrl_test;
   localparam int unsigned NUM  = 12;
   localparam int unsigned RSTN = 1;
   localparam logic [NUM-1:0] BANK = 12'h03C;
   localparam int unsigned EW = 4;
   localparam int unsigned PW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 0, cfg_sec = 0, cfg_en = 0, cfg_route = 0;
   logic [EW-1:0] cfg_num = '0;
   logic pend_set = 0, pend_sec = 0;
   logic [EW-1:0] pend_num = '0;
   logic [EW-1:0] vec_pend_num = '0;
   logic vec_pend_sec = 0;
   logic [PW-1:0] vec_pend_prio = '0, exec_prio = '0;
   logic ack_req = 0, ack_done, ack_err, ack_secure;
   logic [EW-1:0] cur_exc;
   logic cmp_req = 0, cmp_sec = 0, cmp_done;
   logic [EW-1:0] cmp_num = '0;
   logic [1:0] cmp_status;

   int tests = 0;
   int fails = 0;
   bit finished = 0;
   int model_cur = 0;

   always #5 clk = ~clk;

   exc_bank_ctrl #(.NUM_EXC(NUM), .PRIO_W(PW), .RESET_NUM(RSTN), .BANKED_MASK(BANK)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_num(cfg_num), .cfg_sec(cfg_sec),
      .cfg_en(cfg_en), .cfg_route(cfg_route), .pend_set(pend_set), .pend_num(pend_num),
      .pend_sec(pend_sec), .vec_pend_num(vec_pend_num), .vec_pend_sec(vec_pend_sec),
      .vec_pend_prio(vec_pend_prio), .exec_prio(exec_prio), .ack_req(ack_req),
      .ack_done(ack_done), .ack_err(ack_err), .ack_secure(ack_secure), .cur_exc(cur_exc),
      .cmp_req(cmp_req), .cmp_num(cmp_num), .cmp_sec(cmp_sec), .cmp_done(cmp_done),
      .cmp_status(cmp_status)
   );

   function automatic bit is_legal(int n);
      return (n > RSTN) && (n < NUM);
   endfunction
   function automatic bit is_banked(int n);
      return is_legal(n) && BANK[n];
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cfg(input int n, input bit s, input bit en, input bit r);
      @(negedge clk);
      cfg_we = 1; cfg_num = EW'(n); cfg_sec = s; cfg_en = en; cfg_route = r;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic pend(input int n, input bit s);
      @(negedge clk);
      pend_set = 1; pend_num = EW'(n); pend_sec = s;
      @(negedge clk);
      pend_set = 0;
   endtask

   task automatic drive_ack(input int n, input bit s, input int p, input int ex);
      ack_req = 1; vec_pend_num = EW'(n); vec_pend_sec = s;
      vec_pend_prio = PW'(p); exec_prio = PW'(ex);
   endtask

   task automatic drive_cmp(input int n, input bit s);
      cmp_req = 1; cmp_num = EW'(n); cmp_sec = s;
   endtask

   task automatic do_ack(input int n, input bit s, input int p, input int ex);
      @(negedge clk);
      drive_ack(n, s, p, ex);
      @(negedge clk);
      ack_req = 0;
   endtask

   task automatic do_cmp(input int n, input bit s);
      @(negedge clk);
      drive_cmp(n, s);
      @(negedge clk);
      cmp_req = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual 0 expected 1 (run completed)");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 ack_done", int'(ack_done), 0);
      chk("R1 cmp_done", int'(cmp_done), 0);
      chk("R1 cur_exc", int'(cur_exc), 0);
      rst_n = 1;
      do_cmp(4, 0);
      chk("R1 nothing active", int'(cmp_status), 2);
      cfg(4, 0, 1, 0);
      do_ack(4, 0, 1, 5);
      chk("R1 nothing pending", int'(ack_err), 1);
      cfg(4, 0, 0, 0);

      // Sweep: every number, bank flag and routing bit (R2 R3 R4 R6 R7 R9 R11)
      for (int n = 0; n < 16; n++) begin
         for (int s = 0; s < 2; s++) begin
            for (int r = 0; r < 2; r++) begin
               bit ok;
               int esec;
               ok = is_legal(n) && (s == 0 || is_banked(n));
               esec = ok ? ((s == 1) ? 1 : int'(!is_banked(n) && r == 1)) : 0;
               cfg(n, s[0], 1, r[0]);
               pend(n, s[0]);
               do_ack(n, s[0], 2, 5);
               if (ok) model_cur = n;
               chk("R4 ack_done", int'(ack_done), 1);
               chk(is_legal(n) ? "R11 ack_err" : "R9 ack_err", int'(ack_err), int'(!ok));
               chk(s == 1 ? "R2 ack_secure" : "R3 ack_secure", int'(ack_secure), esec);
               chk("R4 cur_exc", int'(cur_exc), model_cur);
               do_cmp(n, s[0]);
               chk(is_legal(n) ? "R6 cmp_status" : "R9 cmp_status", int'(cmp_status), ok ? 1 : 2);
               chk("R8 cmp_done", int'(cmp_done), 1);
               do_cmp(n, s[0]);
               chk("R7 second complete", int'(cmp_status), 2);
               cfg(n, s[0], 0, 0);
            end
         end
      end

      // R5: priority must be strictly lower
      cfg(8, 0, 1, 0);
      pend(8, 0);
      do_ack(8, 0, 5, 5);
      chk("R5 equal prio err", int'(ack_err), 1);
      chk("R5 cur_exc kept", int'(cur_exc), model_cur);
      do_ack(8, 0, 4, 5);
      chk("R5 lower prio ok", int'(ack_err), 0);
      model_cur = 8;
      do_cmp(8, 0);
      chk("R8 base", int'(cmp_status), 1);

      // R5: enabled but not pending; pending but not enabled
      cfg(4, 0, 1, 0);
      do_ack(4, 0, 1, 5);
      chk("R5 not pending", int'(ack_err), 1);
      cfg(5, 0, 0, 0);
      pend(5, 0);
      do_ack(5, 0, 1, 5);
      chk("R5 not enabled", int'(ack_err), 1);
      do_cmp(5, 0);
      chk("R5 no state change", int'(cmp_status), 2);

      // R8: nested completion
      cfg(9, 0, 1, 0); pend(9, 0);
      cfg(10, 0, 1, 1); pend(10, 0);
      do_ack(9, 0, 3, 8);
      do_ack(10, 0, 1, 3);
      chk("R3 routed secure", int'(ack_secure), 1);
      chk("R4 cur nested", int'(cur_exc), 10);
      do_cmp(10, 0);
      chk("R8 still active", int'(cmp_status), 0);
      do_cmp(9, 0);
      chk("R8 back to base", int'(cmp_status), 1);

      // R6: two copies of a banked entry
      cfg(3, 0, 1, 0); pend(3, 0);
      cfg(3, 1, 1, 0); pend(3, 1);
      do_ack(3, 1, 2, 6);
      chk("R2 secure copy", int'(ack_secure), 1);
      do_ack(3, 0, 1, 2);
      chk("R3 banked ns copy", int'(ack_secure), 0);
      do_cmp(3, 0);
      chk("R6 ns copy cleared", int'(cmp_status), 0);
      do_cmp(3, 0);
      chk("R6 ns copy gone", int'(cmp_status), 2);
      do_cmp(3, 1);
      chk("R6 secure copy cleared", int'(cmp_status), 1);

      // R11: secure flag on a non-banked number writes the shared entry
      cfg(7, 1, 1, 1); pend(7, 1);
      do_ack(7, 0, 1, 4);
      chk("R11 shared entry", int'(ack_err), 0);
      chk("R11 route", int'(ack_secure), 1);
      do_cmp(7, 1);
      chk("R11 complete shared", int'(cmp_status), 1);

      // R10: complete and acknowledge in the same cycle
      cfg(7, 0, 1, 0); pend(7, 0);
      cfg(6, 0, 1, 0); pend(6, 0);
      do_ack(7, 0, 2, 6);
      @(negedge clk);
      drive_cmp(7, 0);
      drive_ack(6, 0, 1, 2);
      @(negedge clk);
      cmp_req = 0; ack_req = 0;
      chk("R10 complete first", int'(cmp_status), 1);
      chk("R10 ack applied", int'(ack_err), 0);
      chk("R10 cur_exc", int'(cur_exc), 6);
      do_cmp(6, 0);
      chk("R10 ack entry active", int'(cmp_status), 1);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule